// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial adapter. It watches a serial line on the enables of a receive clock, finds start bits and rejects glitches that are too short to be one, and then takes one sample per bit. It assembles characters of seven or eight data bits, LSB first, checks an optional parity bit and the first stop bit, and hands each finished character to a single holding register. The character shift path and the holding register form a double buffer, so a new character can arrive while the previous one waits to be read.

The receive clock is represented by `rx_en`, a one-cycle pulse on the system clock for each rising edge of the receive clock. The bit rate is the enable rate divided by 1, by `MID_RATE` (16) or by `HIGH_RATE` (64). The word format and the divider are static controls. A carrier-lost input and a master-reset code on the divider select both hold the receiver idle. A read strobe consumes the held character.

Top module: `osrx_receiver`

## Requirements
- R1: In the ÷16 and ÷64 modes (`div_sel` 01 and 10), a start bit is accepted only after MID_RATE/2 (8) or HIGH_RATE/2 (32) consecutive low samples. A high sample before that count restarts the search, so a shorter low pulse never produces a character.
- R2: After an accepted start in the ÷16 and ÷64 modes, each later bit is sampled once, exactly 16 or 64 enables after the previous sample, which places every sample at the bit centre. Data bits arrive LSB first.
- R3: In ÷1 mode (`div_sel` 00), every enable is one bit sample. The first low sample seen while idle is the start bit.
- R4: `word_sel` selects the format. 000 and 001: 7 data bits with even or odd parity. 010 and 011: the same with one stop bit. 100: 8 bits, no parity. 101: 8 bits, no parity, one stop bit. 110 and 111: 8 bits with even or odd parity. For 7-bit words the parity bit is stripped and `rx_data[7]` reads 0.
- R5: Even parity means the data bits plus the parity bit hold an even number of ones; odd parity means an odd number. A mismatch sets `parity_err`. With no parity selected, `parity_err` is 0.
- R6: `frame_err` is set when the first stop bit samples low. Both `frame_err` and `parity_err` are loaded together with their character and hold while it is held.
- R7: A finished character is loaded, and `rx_full` set, on the clock edge of the enable that samples its first stop bit, but only if the register is empty. Otherwise the held byte is kept, `overrun` is set on that edge, and framing of later characters continues.
- R8: A pulse on `rd_strobe` clears `rx_full` and `overrun` and keeps `rx_data`. When a read and a character completion fall in the same cycle, the new character is loaded, `rx_full` stays 1 and `overrun` stays 0.
- R9: While `dcd` is high the receiver is held idle, incoming characters are ignored, and `rx_full` and `overrun` read 0 from the next clock on.
- R10: Reset, or `div_sel` = 11 (master reset), clears `rx_full`, `overrun`, `frame_err` and `parity_err` from the next clock on and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | One pulse per receive-clock rising edge |
| rxd | input | 1 | Serial line, idle high |
| div_sel | input | 2 | 00 ÷1, 01 ÷MID_RATE, 10 ÷HIGH_RATE, 11 master reset |
| word_sel | input | 3 | Word length, parity and stop format (R4) |
| dcd | input | 1 | Carrier lost when high; holds receiver idle |
| rd_strobe | input | 1 | One-cycle read of the held character |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Held character not yet read |
| frame_err | output | 1 | Held character lacked its stop bit |
| parity_err | output | 1 | Held character failed its parity check |
| overrun | output | 1 | A character was lost while the register was full |

## Verification
A character can finish, at its stop-bit sample, in the same clock cycle in which software reads the holding register. The result then depends on which of the two the register favours. The bench schedules the read strobe on exactly the enable that samples the stop bit of a second character. It expects the new byte in the register, `rx_full` still set and no overrun. In a separate case it lets the second character finish with no read, and expects the first byte to be kept and `overrun` to be set.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

   localparam logic [1:0] DIV_1    = 2'b00;
   localparam logic [1:0] DIV_MID  = 2'b01;
   localparam logic [1:0] DIV_HIGH = 2'b10;
   localparam logic [1:0] DIV_MRST = 2'b11;

   localparam int BYTE_W = 8;

   typedef struct packed {
      logic seven;
      logic par_en;
      logic par_odd;
   } fmt_t;

   typedef enum logic [1:0] {
      ST_HUNT,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } frame_st_e;

   function automatic fmt_t decode_fmt(input logic [2:0] ws);
      fmt_t f;
      f.seven   = ~ws[2];
      f.par_en  = ~(ws[2] & ~ws[1]);
      f.par_odd = ws[0];
      return f;
   endfunction

endpackage

// File: rtl/osrx_sampler.sv
module osrx_sampler
   import osrx_pkg::*;
#(
   parameter int MID_RATE    = 16,
   parameter int HIGH_RATE   = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       rxd_i,
   input  logic [1:0] div,
   input  logic       hunt,
   output logic       start_ok,
   output logic       samp,
   output logic       bit_o
);

   localparam int CW = $clog2(HIGH_RATE) + 1;

   initial begin
      assert (MID_RATE >= 2 && (MID_RATE % 2) == 0)
         else $error("MID_RATE must be even and at least 2");
      assert (HIGH_RATE > MID_RATE && (HIGH_RATE % 2) == 0)
         else $error("HIGH_RATE must be even and above MID_RATE");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
   end

   logic line;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line = rxd_i;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= rxd_i;
         end
         assign line = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC_STAGES-2:0], rxd_i};
         end
         assign line = s_q[SYNC_STAGES-1];
      end
   endgenerate

   assign bit_o = line;

   logic [CW-1:0] rate_v;
   logic [CW-1:0] half_v;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;

   always_comb begin
      case (div)
         DIV_MID:  rate_v = CW'(MID_RATE);
         DIV_HIGH: rate_v = CW'(HIGH_RATE);
         default:  rate_v = CW'(1);
      endcase
      half_v = rate_v >> 1;
   end

   always_comb begin
      start_ok = 1'b0;
      samp     = 1'b0;
      cnt_d    = cnt_q;
      if (en) begin
         if (hunt) begin
            if (line) begin
               cnt_d = '0;
            end else if (div == DIV_1) begin
               start_ok = 1'b1;
               cnt_d    = '0;
            end else if (cnt_q + CW'(1) == half_v) begin
               start_ok = 1'b1;
               cnt_d    = '0;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end else begin
            if (cnt_q + CW'(1) == rate_v) begin
               samp  = 1'b1;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_d;
   end

   AST_FALSE_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hunt && en && line) |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/osrx_frame.sv
module osrx_frame
   import osrx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  fmt_t              fmt,
   input  logic              start_ok,
   input  logic              samp,
   input  logic              bit_i,
   output logic              hunt,
   output logic              done,
   output logic [BYTE_W-1:0] data_o,
   output logic              fe_o,
   output logic              pe_o
);

   frame_st_e         st_q;
   logic [2:0]        idx_q;
   logic [BYTE_W-1:0] sh_q;
   logic              pbit_q;
   logic [2:0]        last_idx;

   assign last_idx = fmt.seven ? 3'd6 : 3'd7;
   assign hunt     = (st_q == ST_HUNT);
   assign done     = (st_q == ST_STOP) && samp && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HUNT;
         idx_q  <= '0;
         sh_q   <= '0;
         pbit_q <= 1'b0;
      end else if (clr) begin
         st_q  <= ST_HUNT;
         idx_q <= '0;
      end else begin
         case (st_q)
            ST_HUNT: if (start_ok) begin
               st_q  <= ST_DATA;
               idx_q <= '0;
            end
            ST_DATA: if (samp) begin
               sh_q <= {bit_i, sh_q[BYTE_W-1:1]};
               if (idx_q == last_idx) st_q <= fmt.par_en ? ST_PAR : ST_STOP;
               else                   idx_q <= idx_q + 3'd1;
            end
            ST_PAR: if (samp) begin
               pbit_q <= bit_i;
               st_q   <= ST_STOP;
            end
            default: if (samp) st_q <= ST_HUNT;
         endcase
      end
   end

   assign data_o = fmt.seven ? {1'b0, sh_q[BYTE_W-1:1]} : sh_q;
   assign pe_o   = fmt.par_en & ((^data_o ^ pbit_q) != fmt.par_odd);
   assign fe_o   = ~bit_i;

endmodule

// File: rtl/osrx_hold.sv
module osrx_hold
   import osrx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrst,
   input  logic              carrier_lost,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              fe_i,
   input  logic              pe_i,
   input  logic              rd_i,
   output logic [BYTE_W-1:0] data_q,
   output logic              full_q,
   output logic              fe_q,
   output logic              pe_q,
   output logic              ovr_q
);

   logic take;
   assign take = load_i && (!full_q || rd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         fe_q   <= 1'b0;
         pe_q   <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (mrst) begin
         full_q <= 1'b0;
         fe_q   <= 1'b0;
         pe_q   <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (carrier_lost) begin
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (take) begin
         data_q <= data_i;
         fe_q   <= fe_i;
         pe_q   <= pe_i;
         full_q <= 1'b1;
         ovr_q  <= 1'b0;
      end else if (load_i) begin
         ovr_q  <= 1'b1;
      end else if (rd_i) begin
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end
   end

   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> full_q); // R7

   AST_HELD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !rd_i) |=> $stable(data_q)); // R7

   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !load_i) |=> (!full_q && !ovr_q)); // R8

endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver
   import osrx_pkg::*;
#(
   parameter int MID_RATE    = 16,
   parameter int HIGH_RATE   = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rxd,
   input  logic [1:0]        div_sel,
   input  logic [2:0]        word_sel,
   input  logic              dcd,
   input  logic              rd_strobe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_full,
   output logic              frame_err,
   output logic              parity_err,
   output logic              overrun
);

   logic              mrst;
   logic              clr;
   fmt_t              fmt;
   logic              hunt;
   logic              start_ok;
   logic              samp;
   logic              line_bit;
   logic              done;
   logic [BYTE_W-1:0] char_data;
   logic              char_fe;
   logic              char_pe;

   assign mrst = (div_sel == DIV_MRST);
   assign clr  = mrst | dcd;
   assign fmt  = decode_fmt(word_sel);

   osrx_sampler #(
      .MID_RATE    (MID_RATE),
      .HIGH_RATE   (HIGH_RATE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .en       (rx_en),
      .rxd_i    (rxd),
      .div      (div_sel),
      .hunt     (hunt),
      .start_ok (start_ok),
      .samp     (samp),
      .bit_o    (line_bit)
   );

   osrx_frame u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .fmt      (fmt),
      .start_ok (start_ok),
      .samp     (samp),
      .bit_i    (line_bit),
      .hunt     (hunt),
      .done     (done),
      .data_o   (char_data),
      .fe_o     (char_fe),
      .pe_o     (char_pe)
   );

   osrx_hold u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .mrst         (mrst),
      .carrier_lost (dcd),
      .load_i       (done),
      .data_i       (char_data),
      .fe_i         (char_fe),
      .pe_i         (char_pe),
      .rd_i         (rd_strobe),
      .data_q       (rx_data),
      .full_q       (rx_full),
      .fe_q         (frame_err),
      .pe_q         (parity_err),
      .ovr_q        (overrun)
   );

   AST_DCD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      dcd |=> (!rx_full && !overrun)); // R9

   AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel == DIV_MRST) |=> (!rx_full && !overrun && !frame_err && !parity_err)); // R10

endmodule

// File: tb/osrx_receiver_test.sv
module osrx_receiver_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] div_sel = 2'b11;
   logic [2:0] word_sel = 3'b101;
   logic       dcd = 1'b0;
   logic       tick_rd = 1'b0;
   logic       mon_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, frame_err, parity_err, overrun;

   int checks = 0;
   int errors = 0;
   bit auto_rd = 1'b0;
   bit finished = 1'b0;

   logic [9:0] q_exp[$];
   string      q_req[$];

   always #5 clk = ~clk;

   osrx_receiver uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .rxd        (rxd),
      .div_sel    (div_sel),
      .word_sel   (word_sel),
      .dcd        (dcd),
      .rd_strobe  (tick_rd | mon_rd),
      .rx_data    (rx_data),
      .rx_full    (rx_full),
      .frame_err  (frame_err),
      .parity_err (parity_err),
      .overrun    (overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // one receive-clock enable; the line settles two clocks before it
   task automatic tick(input bit rd_now);
      repeat (2) @(negedge clk);
      rx_en   = 1'b1;
      tick_rd = rd_now;
      @(negedge clk);
      rx_en   = 1'b0;
      tick_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      rxd = 1'b1;
      for (int i = 0; i < n; i++) tick(1'b0);
   endtask

   task automatic do_read();
      @(negedge clk);
      tick_rd = 1'b1;
      @(negedge clk);
      tick_rd = 1'b0;
   endtask

   function automatic int cur_rate();
      if (div_sel == 2'b01) return 16;
      if (div_sel == 2'b10) return 64;
      return 1;
   endfunction

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                             input bit rd_at_stop, input bit push, input string req);
      logic [11:0] bits;
      int n, stop_k, rate, mid;
      bit seven, par_en, odd, p;
      logic [7:0] ed;
      seven  = ~word_sel[2];
      par_en = ~(word_sel[2] & ~word_sel[1]);
      odd    = word_sel[0];
      rate   = cur_rate();
      mid    = (rate == 1) ? 1 : rate / 2;
      bits   = '1;
      bits[0] = 1'b0;
      n = 1;
      p = 1'b0;
      for (int i = 0; i < (seven ? 7 : 8); i++) begin
         bits[n] = d[i];
         p = p ^ d[i];
         n++;
      end
      if (par_en) begin
         bits[n] = p ^ odd ^ bad_par;
         n++;
      end
      stop_k = n;
      bits[n] = ~bad_stop;
      n++;
      if (word_sel[2:1] == 2'b00 || word_sel == 3'b100) n++;
      ed = seven ? {1'b0, d[6:0]} : d;
      if (push) begin
         q_exp.push_back({ed, bad_stop, par_en & bad_par});
         q_req.push_back(req);
      end
      for (int k = 0; k < n; k++) begin
         rxd = bits[k];
         for (int i = 1; i <= rate; i++) tick(rd_at_stop && k == stop_k && i == mid);
      end
      rxd = 1'b1;
   endtask

   // monitor: pops the scoreboard each time a character is held
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rd && rx_full) begin
            if (q_exp.size() == 0) begin
               chk("R1 unexpected character", {24'h0, rx_data}, 32'hFFFF);
            end else begin
               logic [9:0] e;
               string r;
               e = q_exp.pop_front();
               r = q_req.pop_front();
               chk(r, {22'h0, rx_data, frame_err, parity_err}, {22'h0, e});
            end
            mon_rd = 1'b1;
            @(negedge clk);
            mon_rd = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   task automatic drain();
      int guard;
      guard = 0;
      while ((q_exp.size() != 0 || rx_full) && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      chk("R2 scoreboard drained", q_exp.size(), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset full", rx_full, 0);
      chk("R10 reset flags", {frame_err, parity_err, overrun}, 0);
      chk("R10 reset data", rx_data, 0);

      // scoreboard phase
      auto_rd = 1'b1;
      div_sel = 2'b01; idle(4);
      word_sel = 3'b101; send_frame(8'hA5, 0, 0, 0, 1, "R2 div16 8N1"); idle(4);
      word_sel = 3'b110; send_frame(8'h3C, 0, 0, 0, 1, "R5 even parity good"); idle(4);
      word_sel = 3'b111; send_frame(8'h81, 1, 0, 0, 1, "R5 odd parity bad"); idle(4);
      word_sel = 3'b010; send_frame(8'hFF, 0, 0, 0, 1, "R4 seven-bit strip"); idle(4);
      word_sel = 3'b011; send_frame(8'h55, 1, 0, 0, 1, "R4 R5 seven-bit odd bad"); idle(4);
      drain();
      div_sel = 2'b10; idle(2);
      word_sel = 3'b101; send_frame(8'h5A, 0, 0, 0, 1, "R2 div64 8N1"); idle(2);
      word_sel = 3'b000; send_frame(8'h12, 0, 0, 0, 1, "R2 div64 7E2"); idle(2);
      drain();
      div_sel = 2'b00; idle(4);
      word_sel = 3'b101; send_frame(8'hC3, 0, 0, 0, 1, "R3 div1 8N1"); idle(2);
      word_sel = 3'b110; send_frame(8'h0F, 0, 1, 0, 1, "R6 missing stop"); idle(2);
      word_sel = 3'b100; send_frame(8'h01, 1, 0, 0, 1, "R5 parity suppressed"); idle(2);
      drain();

      // false starts, R1
      div_sel = 2'b01; word_sel = 3'b101; idle(4);
      rxd = 1'b0; for (int i = 0; i < 7; i++) tick(1'b0);
      idle(20);
      chk("R1 short pulse div16", rx_full, 0);
      send_frame(8'h96, 0, 0, 0, 1, "R1 aligned after glitch div16"); idle(4);
      drain();
      div_sel = 2'b10; idle(2);
      rxd = 1'b0; for (int i = 0; i < 31; i++) tick(1'b0);
      idle(70);
      chk("R1 short pulse div64", rx_full, 0);
      send_frame(8'h69, 0, 0, 0, 1, "R1 aligned after glitch div64"); idle(2);
      drain();
      auto_rd = 1'b0;

      // overrun and read, R7 R8
      div_sel = 2'b01; word_sel = 3'b101; idle(4);
      send_frame(8'h11, 0, 0, 0, 0, ""); idle(4);
      chk("R7 first held", {rx_full, overrun, rx_data}, {2'b10, 8'h11});
      send_frame(8'h22, 0, 0, 0, 0, ""); idle(4);
      chk("R7 overrun keeps byte", {rx_full, overrun, rx_data}, {2'b11, 8'h11});
      send_frame(8'h33, 0, 0, 0, 0, ""); idle(4);
      chk("R7 still kept", rx_data, 8'h11);
      do_read();
      @(negedge clk);
      chk("R8 read clears", {rx_full, overrun, rx_data}, {2'b00, 8'h11});
      send_frame(8'h44, 0, 0, 0, 0, ""); idle(4);
      chk("R7 framing continued", {rx_full, rx_data}, {1'b1, 8'h44});
      send_frame(8'h55, 0, 0, 1, 0, ""); idle(4);
      chk("R8 read with completion", {rx_full, overrun, rx_data}, {2'b10, 8'h55});
      do_read();

      // carrier loss, R9
      send_frame(8'h66, 0, 0, 0, 0, ""); idle(2);
      @(negedge clk); dcd = 1'b1;
      @(negedge clk);
      chk("R9 full reads empty", rx_full, 0);
      send_frame(8'h77, 0, 0, 0, 0, ""); idle(4);
      chk("R9 ignored while lost", rx_full, 0);
      dcd = 1'b0; idle(4);
      send_frame(8'h78, 0, 0, 0, 0, ""); idle(4);
      chk("R9 recovered", {rx_full, rx_data}, {1'b1, 8'h78});

      // master reset, R10 R6
      do_read();
      div_sel = 2'b00; idle(4);
      send_frame(8'hE7, 0, 1, 0, 0, ""); idle(2);
      chk("R6 error held", {rx_full, frame_err, rx_data}, {2'b11, 8'hE7});
      send_frame(8'h18, 0, 0, 0, 0, ""); idle(2);
      chk("R6 flag kept on overrun", {frame_err, overrun}, 2'b11);
      @(negedge clk); div_sel = 2'b11;
      @(negedge clk);
      chk("R10 master reset", {rx_full, overrun, frame_err, parity_err}, 0);
      div_sel = 2'b00; idle(4);
      send_frame(8'h3E, 0, 0, 0, 0, ""); idle(2);
      chk("R10 works after reset", {rx_full, frame_err, rx_data}, {2'b10, 8'h3E});

      finish_run();
   end

endmodule